// File: doc/BRIEF.md
# Masked Interrupt Pending Register Block

This block sits in a byte-wide memory-mapped I/O window and collects up to eight interrupt sources into one level-sensitive interrupt line for the CPU-side router. Side-band vectors set or clear bits in a raw pending register. A primary enable mask selects which pending bits can drive the line. The line is high whenever at least one pending bit is also enabled. There is no priority resolution, no vector generation and no in-service state.

Software reaches the block through a request/response stream. A request carries a byte offset, a size code, a write flag and a write byte. Every accepted request gets exactly one response, which carries the read data and an error flag. The request side is ready whenever the response slot is empty or is being drained in that cycle. A response that is not taken stays valid and unchanged. A stalled response therefore back-pressures new requests, and no request is lost or doubled.

The primary mask is written inverted: a written 1 disables the source, and a read returns the written byte. A second, non-functional mask register is stored as written. Several write-only placeholder offsets are accepted with no effect. Undecoded offsets and illegal sizes return an error and change nothing.

Top module: `irq_regblk`

## Requirements
- R1: After reset, irq is low, the pending register is zero, and a read of the primary mask (0x21) or of the secondary mask (0xA1) returns 0xFF.
- R2: A byte write to 0x21 stores the complement of the byte as the enable mask (enable bit i = 1 means source i may interrupt). A byte read of 0x21 returns the complement of the stored enable, which is the last byte written.
- R3: irq is high exactly when (pending AND enable) is nonzero. It follows every change of pending or enable at the same clock edge that updates them.
- R4: A byte write to 0x20 is an acknowledge. It clears the pending bit whose index is wdata[3:0], and it wins over a set-pending of the same bit in the same cycle.
- R5: An acknowledge with index 8 to 15 leaves the pending register unchanged.
- R6: In each cycle, set_vec is ORed into pending and the bits of clr_vec are cleared. When both name the same bit, clr_vec wins.
- R7: A read of 0x20 with size code 0 (1 byte) or 3 (8 bytes) returns the raw, unmasked pending register, zero-extended to 64 bits.
- R8: A byte read of 0xA0 returns zero. A byte write of 0xA1 stores the byte unchanged, and a read of 0xA1 returns it. The secondary mask never affects irq.
- R9: Byte writes to the placeholder offsets 0x08, 0x0A, 0x0B, 0x0D, 0x0F, 0x60, 0x61, 0xA0, 0xD0, 0xD4, 0xD6, 0xDA and 0xDE complete without error and change neither the masks nor the pending register.
- R10: The response has rsp_err=1 and rdata zero in these cases: any size code other than 0, except an 8-byte read of 0x20; any undecoded offset; a read of a placeholder offset. An erroring request changes no state.
- R11: req_ready equals (!rsp_valid || rsp_ready). A request is accepted when req_valid and req_ready are both high, and its response is valid from the next cycle. While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_rdata and rsp_err hold, and no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset in the window |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 64 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Access error |
| set_vec | input | 8 | Pending-set bits, one cycle per pulse |
| clr_vec | input | 8 | Pending-clear bits, one cycle per pulse |
| irq | output | 1 | Level interrupt toward the CPU |

## Verification
Pending, mask and irq changes all take effect at the rising edge that samples the stimulus, whether that is an accepted write or a side-band pulse. Responses become valid after the edge that accepts the request. Read data reflects the state held before that edge. The bench drives inputs on falling edges and samples outputs on the next falling edge, so each result is read exactly one edge after its cause. In the back-pressure sequence it holds rsp_ready low for several cycles and checks that the response stays frozen and that a request offered during the stall is not accepted.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int unsigned OFF_W = 8;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } size_e;

  typedef enum logic [3:0] {
    OP_BAD      = 4'd0,
    OP_STAT_RD  = 4'd1,
    OP_ACK_WR   = 4'd2,
    OP_MSK_RD   = 4'd3,
    OP_MSK_WR   = 4'd4,
    OP_STAT2_RD = 4'd5,
    OP_MSK2_RD  = 4'd6,
    OP_MSK2_WR  = 4'd7,
    OP_NOP_WR   = 4'd8
  } op_e;

  localparam logic [OFF_W-1:0] OFF_STAT  = 8'h20;
  localparam logic [OFF_W-1:0] OFF_MASK  = 8'h21;
  localparam logic [OFF_W-1:0] OFF_STAT2 = 8'hA0;
  localparam logic [OFF_W-1:0] OFF_MASK2 = 8'hA1;

  function automatic logic is_nop_off(input logic [OFF_W-1:0] off);
    case (off)
      8'h08, 8'h0A, 8'h0B, 8'h0D, 8'h0F,
      8'h60, 8'h61,
      8'hD0, 8'hD4, 8'hD6, 8'hDA, 8'hDE: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/irq_decode.sv
module irq_decode
  import irq_pkg::*;
(
  input  logic             wr,
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       size,
  output op_e              op
);
  logic byte_sz;
  assign byte_sz = (size == SZ_B1);

  always_comb begin
    op = OP_BAD;
    case (off)
      OFF_STAT: begin
        if (!wr && (byte_sz || size == SZ_B8)) op = OP_STAT_RD;
        else if (wr && byte_sz)                op = OP_ACK_WR;
      end
      OFF_MASK:  if (byte_sz) op = wr ? OP_MSK_WR  : OP_MSK_RD;
      OFF_STAT2: if (byte_sz) op = wr ? OP_NOP_WR  : OP_STAT2_RD;
      OFF_MASK2: if (byte_sz) op = wr ? OP_MSK2_WR : OP_MSK2_RD;
      default:   if (byte_sz && wr && is_nop_off(off)) op = OP_NOP_WR;
    endcase
  end
endmodule

// File: rtl/irq_state.sv
module irq_state
  import irq_pkg::*;
#(
  parameter int unsigned SRC_N = 8,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  op_e              op,
  input  logic [SRC_N-1:0] wdata,
  input  logic [SRC_N-1:0] set_vec,
  input  logic [SRC_N-1:0] clr_vec,
  output logic [SRC_N-1:0] pending,
  output logic [SRC_N-1:0] enable,
  output logic [SRC_N-1:0] mask2,
  output logic             irq
);
  localparam int unsigned SEL_W = (SRC_N > 1) ? $clog2(SRC_N) : 1;
  localparam logic [IDX_W:0] SRC_LIM = (IDX_W+1)'(SRC_N);

  logic [SRC_N-1:0] pend_nx, en_nx, m2_nx, ack_hit;
  logic [IDX_W-1:0] ack_idx;
  logic             ack_fire;

  assign ack_idx  = wdata[IDX_W-1:0];
  assign ack_fire = acc && (op == OP_ACK_WR);

  // Per-source pending update: acknowledge and clear beat set.
  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    assign ack_hit[i] = ack_fire && (ack_idx == IDX_W'(i));
    assign pend_nx[i] = (pending[i] | set_vec[i]) & ~clr_vec[i] & ~ack_hit[i];
  end

  assign en_nx = (acc && op == OP_MSK_WR)  ? ~wdata : enable;
  assign m2_nx = (acc && op == OP_MSK2_WR) ? wdata  : mask2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      enable  <= '0;
      mask2   <= '1;
      irq     <= 1'b0;
    end else begin
      pending <= pend_nx;
      enable  <= en_nx;
      mask2   <= m2_nx;
      irq     <= |(pend_nx & en_nx);
    end
  end

  a_r3_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(pending & enable)));

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && ({1'b0, ack_idx} < SRC_LIM))
      |=> !pending[$past(ack_idx[SEL_W-1:0])]);

  a_r5_ack_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && ({1'b0, ack_idx} >= SRC_LIM) && set_vec == '0 && clr_vec == '0)
      |=> pending == $past(pending));

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((pending & $past(clr_vec)) == '0));

  a_r10_error_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_BAD) |=> ($stable(enable) && $stable(mask2)));
endmodule

// File: rtl/irq_resp.sv
module irq_resp
  import irq_pkg::*;
#(
  parameter int unsigned SRC_N = 8,
  parameter int unsigned RD_W  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  op_e              op,
  input  logic [SRC_N-1:0] pending,
  input  logic [SRC_N-1:0] enable,
  input  logic [SRC_N-1:0] mask2,
  input  logic             rsp_ready,
  output logic             rsp_valid,
  output logic [RD_W-1:0]  rsp_rdata,
  output logic             rsp_err
);
  localparam int unsigned PAD_W = RD_W - SRC_N;

  logic [RD_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (op)
      OP_STAT_RD: rd_mux = {{PAD_W{1'b0}}, pending};
      OP_MSK_RD:  rd_mux = {{PAD_W{1'b0}}, ~enable};
      OP_MSK2_RD: rd_mux = {{PAD_W{1'b0}}, mask2};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
      rsp_err   <= (op == OP_BAD);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready)
      |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  a_r10_error_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));
endmodule

// File: rtl/irq_regblk.sv
module irq_regblk
  import irq_pkg::*;
#(
  parameter int unsigned SRC_N = 8,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned RD_W  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [7:0]       req_offset,
  input  logic [1:0]       req_size,
  input  logic [SRC_N-1:0] req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [RD_W-1:0]  rsp_rdata,
  output logic             rsp_err,
  input  logic [SRC_N-1:0] set_vec,
  input  logic [SRC_N-1:0] clr_vec,
  output logic             irq
);
  op_e              op;
  logic             acc;
  logic [SRC_N-1:0] pending, enable, mask2;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  irq_decode u_dec (
    .wr   (req_write),
    .off  (req_offset),
    .size (req_size),
    .op   (op)
  );

  irq_state #(.SRC_N(SRC_N), .IDX_W(IDX_W)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .op      (op),
    .wdata   (req_wdata),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .pending (pending),
    .enable  (enable),
    .mask2   (mask2),
    .irq     (irq)
  );

  irq_resp #(.SRC_N(SRC_N), .RD_W(RD_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .op        (op),
    .pending   (pending),
    .enable    (enable),
    .mask2     (mask2),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  a_r11_accept_only_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !acc);

  a_r8_mask2_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_MSK2_WR && set_vec == '0 && clr_vec == '0)
      |=> irq == $past(irq));
endmodule

// File: tb/sim_irq_regblk.sv
`timescale 1ns/1ps
module sim_irq_regblk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_offset = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        req_ready, rsp_valid, rsp_err, irq;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_rdata;
  logic [7:0]  set_vec = '0, clr_vec = '0;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_pend = '0, m_en = '0, m_m2 = 8'hFF;

  always #5 clk = ~clk;

  irq_regblk u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .set_vec(set_vec),
    .clr_vec(clr_vec), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic placeholder(input logic [7:0] off);
    case (off)
      8'h08, 8'h0A, 8'h0B, 8'h0D, 8'h0F, 8'h60, 8'h61,
      8'hD0, 8'hD4, 8'hD6, 8'hDA, 8'hDE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_err(input logic w, input logic [7:0] off, input logic [1:0] sz);
    if (off == 8'h20 && !w && sz == 2'd3) return 1'b0;
    if (sz != 2'd0) return 1'b1;
    if (off == 8'h20 || off == 8'h21 || off == 8'hA0 || off == 8'hA1) return 1'b0;
    return !(w && placeholder(off));
  endfunction

  function automatic logic [63:0] exp_rd(input logic w, input logic [7:0] off, input logic [1:0] sz);
    if (w || exp_err(w, off, sz)) return 64'd0;
    case (off)
      8'h20:   return {56'd0, m_pend};
      8'h21:   return {56'd0, ~m_en};
      8'hA1:   return {56'd0, m_m2};
      default: return 64'd0;
    endcase
  endfunction

  task automatic chk_irq(input string req);
    check(req, {63'd0, irq}, {63'd0, |(m_pend & m_en)});
  endtask

  task automatic bus(input string req, input logic w, input logic [7:0] off,
                     input logic [1:0] sz, input logic [7:0] wd);
    logic [63:0] e_rd;
    logic        e_er;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_offset = off; req_size = sz; req_wdata = wd;
    e_rd = exp_rd(w, off, sz);
    e_er = exp_err(w, off, sz);
    @(posedge clk);
    if (!e_er && w) begin
      if (off == 8'h20 && wd[3:0] < 4'd8) m_pend[wd[2:0]] = 1'b0;
      if (off == 8'h21) m_en = ~wd;
      if (off == 8'hA1) m_m2 = wd;
    end
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R11 valid"}, {63'd0, rsp_valid}, 64'd1);
    check({req, " data"}, rsp_rdata, e_rd);
    check({req, " R10 err"}, {63'd0, rsp_err}, {63'd0, e_er});
    chk_irq({req, " R3 irq"});
  endtask

  task automatic side(input logic [7:0] s, input logic [7:0] c);
    @(negedge clk);
    set_vec = s; clr_vec = c;
    @(posedge clk);
    m_pend = (m_pend | s) & ~c;
    @(negedge clk);
    set_vec = '0; clr_vec = '0;
    chk_irq("R6 R3 side-band irq");
    bus("R6 R7 pending after side-band", 1'b0, 8'h20, 2'd0, 8'h00);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq at reset", {63'd0, irq}, 64'd0);
    check("R11 ready at reset", {63'd0, req_ready}, 64'd1);
    bus("R1 primary mask reset", 1'b0, 8'h21, 2'd0, 8'h00);
    bus("R1 secondary mask reset", 1'b0, 8'hA1, 2'd0, 8'h00);
    bus("R1 pending reset", 1'b0, 8'h20, 2'd0, 8'h00);

    // R6 pending with all sources disabled; R3 irq stays low
    side(8'h05, 8'h00);
    // R2 enable bit 2 by writing its complement
    bus("R2 mask write", 1'b1, 8'h21, 2'd0, 8'hFB);
    bus("R2 mask readback", 1'b0, 8'h21, 2'd0, 8'h00);
    // R7 64-bit status read
    bus("R7 wide status read", 1'b0, 8'h20, 2'd3, 8'h00);
    // R5 ack index out of range
    bus("R5 ack idx 10", 1'b1, 8'h20, 2'd0, 8'h0A);
    bus("R5 pending unchanged", 1'b0, 8'h20, 2'd0, 8'h00);
    // R4 ack bit 2 drops irq
    bus("R4 ack idx 2", 1'b1, 8'h20, 2'd0, 8'hF2);
    bus("R4 pending after ack", 1'b0, 8'h20, 2'd0, 8'h00);
    // R6 clear beats set on the same bit
    side(8'h84, 8'h04);
    // R8 secondary mask and status
    bus("R8 secondary mask write", 1'b1, 8'hA1, 2'd0, 8'h00);
    bus("R8 secondary mask read", 1'b0, 8'hA1, 2'd0, 8'h00);
    bus("R8 secondary status", 1'b0, 8'hA0, 2'd0, 8'h00);
    // R9 placeholder writes
    bus("R9 placeholder 0x0B", 1'b1, 8'h0B, 2'd0, 8'h00);
    bus("R9 placeholder 0xA0", 1'b1, 8'hA0, 2'd0, 8'h07);
    bus("R9 masks intact", 1'b0, 8'h21, 2'd0, 8'h00);
    // R10 errors
    bus("R10 wide mask write", 1'b1, 8'h21, 2'd1, 8'h00);
    bus("R10 wide ack", 1'b1, 8'h20, 2'd3, 8'h01);
    bus("R10 undecoded", 1'b0, 8'h33, 2'd0, 8'h00);
    bus("R10 placeholder read", 1'b0, 8'h61, 2'd0, 8'h00);
    bus("R10 mask intact", 1'b0, 8'h21, 2'd0, 8'h00);

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_offset = 8'h21; req_size = 2'd0;
    @(negedge clk);
    req_write = 1'b1; req_wdata = 8'h00;   // offered during stall, must not land
    check("R11 stalled valid", {63'd0, rsp_valid}, 64'd1);
    check("R11 ready low", {63'd0, req_ready}, 64'd0);
    check("R11 stalled data", rsp_rdata, {56'd0, ~m_en});
    held = rsp_rdata;
    repeat (2) @(negedge clk);
    check("R11 data held", rsp_rdata, held);
    check("R11 valid held", {63'd0, rsp_valid}, 64'd1);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R11 drained", {63'd0, rsp_valid}, 64'd0);
    bus("R11 stalled write not taken", 1'b0, 8'h21, 2'd0, 8'h00);

    // random mix
    for (int k = 0; k < 400; k++) begin
      int unsigned pick;
      logic [7:0]  off;
      logic [1:0]  sz;
      pick = $urandom_range(0, 5);
      sz   = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'd0;
      case (pick)
        0: side(8'($urandom), 8'($urandom) & 8'($urandom));
        1: bus("R2 random mask", 1'b1, 8'h21, 2'd0, 8'($urandom));
        2: bus("R4 random ack", 1'b1, 8'h20, 2'd0, 8'($urandom));
        3: bus("R7 random status", 1'b0, 8'h20, sz, 8'h00);
        4: begin
          case ($urandom_range(0, 3))
            0: off = 8'hA1;
            1: off = 8'hD6;
            2: off = 8'h21;
            default: off = 8'($urandom);
          endcase
          bus("R9 R10 random access", 1'($urandom), off, sz, 8'($urandom));
        end
        default: bus("R8 random secondary", 1'b1, 8'hA1, 2'd0, 8'($urandom));
      endcase
    end
    finish_run();
  end
endmodule